// File: doc/BRIEF.md
# Flash garbage collection relocator

This block hands out physical pages for two append-only pools on a flash array. One pool holds user data pages; the other holds translation pages, which store slices of the logical-to-physical map. Each pool owns one open block that fills in page order. When that block is full, the pool takes the lowest-numbered erased block. Every page is either erased, valid or invalid, and the logical number written into it is kept beside its state.

When the count of erased blocks drops below a threshold, the block reclaims space and holds off new writes. It first picks the full block with the fewest valid pages. It then moves each live page of that block into the open block of the same pool and fixes the map for each moved page, then erases the victim.

- A moved translation page is patched straight into the directory.
- A moved data page updates the mapping cache if that cache holds its logical number.
- Otherwise the new mapping is staged, and a rewrite of the owning translation page is issued. Consecutive staged mappings that share one translation page share a single rewrite.

Top module: `fgc_reloc`

## Requirements
- R1: Each write gets the next page of its pool's open block, with page address = block * PAGES_PER_BLOCK + offset. After the last page of a block, the pool opens the lowest-numbered erased block and the erased-block count drops by one. After reset, block 0 is the open data block (kind 0), block 1 is the open translation block (kind 1), and every other block is erased.
- R2: A write with the old-page flag set marks the given old page invalid, so that page no longer counts as live for victim choice or relocation.
- R3: Reclamation starts in the idle cycle after the erased-block count falls below THRESH, and not while the count is at THRESH or above. wr_ready is low whenever the erased-block count is below THRESH or reclamation is running.
- R4: The victim is the full (not open) block with the fewest valid pages; a tie goes to the lowest block number.
- R5: For a translation victim, each valid page is copied (command 1, source old page, destination new page in the translation pool) and, in the same cycle, a directory write is made with the page's logical number and the new page address.
- R6: For a data victim page whose logical number hits the mapping cache, the copy (command 1) is accompanied by a cache update carrying the logical number and new page, and nothing is staged for it.
- R7: For a data victim page that misses the cache, the copy is accompanied by a stage strobe with the logical number and new page. Misses in the same translation page (logical number / EPT) share one rewrite. A miss in a different translation page first flushes the pending one, before the copy.
- R8: A translation rewrite takes the next page of the translation pool and issues command 2, with the old translation page as source (zero when the directory has none) and the new page as destination. It also writes the directory entry and marks the old translation page invalid.
- R9: After the last victim page, command 3 is issued, with the first page address of the victim as destination. One cycle later the erased-block count is one higher, and the block is available for reuse.
- R10: Right after reset, the erased-block count is NBLK-2, wr_ready is high and gc_busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Page allocation request |
| wr_kind | input | 1 | Pool: 0 data, 1 translation |
| wr_lpn | input | LW | Logical number stored with the page |
| wr_old_vld | input | 1 | An old copy of this page exists |
| wr_old_ppn | input | PW | Old copy to invalidate |
| wr_ready | output | 1 | Allocation accepted this cycle |
| wr_ppn | output | PW | Page handed out |
| gc_busy | output | 1 | Reclamation running |
| free_blocks | output | BW+1 | Erased-block count |
| cmd_vld | output | 1 | Flash command valid |
| cmd_op | output | 2 | 1 copy, 2 translation rewrite, 3 erase |
| cmd_src | output | PW | Source page |
| cmd_dst | output | PW | Destination page, or first page of erased block |
| map_lpn | output | LW | Logical number of moved page (cache lookup) |
| map_ppn | output | PW | New page of moved page |
| cache_hit | input | 1 | Cache holds map_lpn (same cycle) |
| cache_wr | output | 1 | Update cached mapping |
| stage_wr | output | 1 | Stage mapping for the pending rewrite |
| gtd_wr | output | 1 | Directory write |
| gtd_idx | output | LW | Directory index |
| gtd_ppn | output | PW | Directory new page |
| gtd_rd_idx | output | LW | Directory lookup index |
| gtd_rd_vld | input | 1 | Directory entry exists |
| gtd_rd_ppn | input | PW | Directory entry page |

## Verification
The checker takes for granted that the cache and directory lookups answer in the same cycle as they are presented. It also assumes that cache_hit is the only thing choosing between a cache update and a staged mapping. Under those assumptions, every data copy goes one way or the other, and every rewrite writes the directory index it read. It further assumes that a write is offered only while wr_ready is high and that an old page named on a write really holds that logical number. The bench models the cache and directory as combinational maps and offers writes only after seeing wr_ready. It overwrites only pages it allocated itself and keeps enough erased blocks for a relocation to complete.

// File: rtl/fgc_reloc.sv
module fgc_reloc #(
  parameter int NBLK   = 8,
  parameter int PPB    = 4,
  parameter int LW     = 8,
  parameter int EPT    = 4,
  parameter int THRESH = 2,
  localparam int BW = $clog2(NBLK),
  localparam int PW = $clog2(NBLK*PPB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_kind,
  input  logic [LW-1:0] wr_lpn,
  input  logic          wr_old_vld,
  input  logic [PW-1:0] wr_old_ppn,
  output logic          wr_ready,
  output logic [PW-1:0] wr_ppn,
  output logic          gc_busy,
  output logic [BW:0]   free_blocks,
  output logic          cmd_vld,
  output logic [1:0]    cmd_op,
  output logic [PW-1:0] cmd_src,
  output logic [PW-1:0] cmd_dst,
  output logic [LW-1:0] map_lpn,
  output logic [PW-1:0] map_ppn,
  input  logic          cache_hit,
  output logic          cache_wr,
  output logic          stage_wr,
  output logic          gtd_wr,
  output logic [LW-1:0] gtd_idx,
  output logic [PW-1:0] gtd_ppn,
  output logic [LW-1:0] gtd_rd_idx,
  input  logic          gtd_rd_vld,
  input  logic [PW-1:0] gtd_rd_ppn
);
  localparam int NPG = NBLK * PPB;
  localparam int OW  = $clog2(PPB);
  localparam int CW  = $clog2(PPB + 1);
  localparam int EW  = $clog2(EPT);
  localparam logic [BW:0] THR   = (BW+1)'(THRESH);
  localparam logic [OW-1:0] LAST = OW'(PPB - 1);
  localparam logic [1:0] PG_ERASED = 2'd0, PG_VALID = 2'd1, PG_INVALID = 2'd2;
  localparam logic [1:0] BK_FREE = 2'd0, BK_OPEN = 2'd1, BK_FULL = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FLUSH, S_ERASE} st_t;

  logic [1:0]    pst   [NPG];
  logic [LW-1:0] plpn  [NPG];
  logic [1:0]    bst   [NBLK];
  logic          bkind [NBLK];
  logic [BW-1:0] cur   [2];
  logic [OW-1:0] wp    [2];

  st_t           st;
  logic [BW-1:0] vic;
  logic          vkind, pend, fin;
  logic [OW-1:0] ptr;
  logic [LW-1:0] ptp;

  logic [CW-1:0] vcnt [NBLK];
  logic [CW-1:0] vbest;
  logic [BW-1:0] vsel, low_free;
  logic          vfound;

  always_comb begin
    for (int b = 0; b < NBLK; b++) begin
      vcnt[b] = '0;
      for (int p = 0; p < PPB; p++)
        vcnt[b] = vcnt[b] + CW'(pst[b*PPB + p] == PG_VALID);
    end
    vfound = 1'b0;
    vsel   = '0;
    vbest  = '0;
    for (int b = 0; b < NBLK; b++)
      if (bst[b] == BK_FULL && (!vfound || vcnt[b] < vbest)) begin
        vfound = 1'b1;
        vsel   = BW'(b);
        vbest  = vcnt[b];
      end
    low_free = '0;
    for (int b = NBLK - 1; b >= 0; b--)
      if (bst[b] == BK_FREE) low_free = BW'(b);
  end

  wire [PW-1:0] sp        = {vic, ptr};
  wire          s_valid   = pst[sp] == PG_VALID;
  wire [LW-1:0] s_lpn     = plpn[sp];
  wire [LW-1:0] s_tp      = s_lpn >> EW;
  wire          is_data   = !vkind;
  wire          miss      = st == S_SCAN && is_data && s_valid && !cache_hit;
  wire          mid_flush = miss && pend && s_tp != ptp;
  wire          do_copy   = st == S_SCAN && s_valid && !mid_flush;
  wire          flushing  = st == S_FLUSH;
  wire          host_wr   = wr_en && wr_ready;
  wire          alloc_en  = host_wr || do_copy || flushing;
  wire          akind     = host_wr ? wr_kind : (flushing ? 1'b1 : vkind);
  wire [LW-1:0] alpn      = host_wr ? wr_lpn : (flushing ? ptp : s_lpn);
  wire [PW-1:0] appn      = {cur[akind], wp[akind]};
  wire          wrap      = alloc_en && wp[akind] == LAST;

  assign wr_ready   = st == S_IDLE && free_blocks >= THR;
  assign wr_ppn     = appn;
  assign gc_busy    = st != S_IDLE;
  assign cmd_vld    = do_copy || flushing || st == S_ERASE;
  assign cmd_op     = st == S_ERASE ? 2'd3 : (flushing ? 2'd2 : 2'd1);
  assign cmd_src    = flushing ? (gtd_rd_vld ? gtd_rd_ppn : '0) : sp;
  assign cmd_dst    = st == S_ERASE ? {vic, OW'(0)} : appn;
  assign map_lpn    = s_lpn;
  assign map_ppn    = appn;
  assign cache_wr   = do_copy && is_data && cache_hit;
  assign stage_wr   = do_copy && is_data && !cache_hit;
  assign gtd_wr     = (do_copy && !is_data) || flushing;
  assign gtd_idx    = flushing ? ptp : s_lpn;
  assign gtd_ppn    = appn;
  assign gtd_rd_idx = ptp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPG; i++) begin
        pst[i]  <= PG_ERASED;
        plpn[i] <= '0;
      end
      for (int b = 0; b < NBLK; b++) begin
        bst[b]   <= (b < 2) ? BK_OPEN : BK_FREE;
        bkind[b] <= (b == 1);
      end
      cur[0] <= BW'(0);
      cur[1] <= BW'(1);
      wp[0]  <= '0;
      wp[1]  <= '0;
      free_blocks <= (BW+1)'(NBLK - 2);
      st   <= S_IDLE;
      vic  <= '0;
      vkind <= 1'b0;
      pend <= 1'b0;
      fin  <= 1'b0;
      ptr  <= '0;
      ptp  <= '0;
    end else begin
      if (alloc_en) begin
        pst[appn]  <= PG_VALID;
        plpn[appn] <= alpn;
        if (wrap) begin
          bst[cur[akind]] <= BK_FULL;
          bst[low_free]   <= BK_OPEN;
          bkind[low_free] <= akind;
          cur[akind]      <= low_free;
          wp[akind]       <= '0;
        end else begin
          wp[akind] <= wp[akind] + 1'b1;
        end
      end
      if (host_wr && wr_old_vld) pst[wr_old_ppn] <= PG_INVALID;
      if (do_copy) pst[sp] <= PG_INVALID;
      if (flushing && gtd_rd_vld) pst[gtd_rd_ppn] <= PG_INVALID;

      if (st == S_ERASE) free_blocks <= free_blocks + 1'b1;
      else if (wrap)     free_blocks <= free_blocks - 1'b1;

      case (st)
        S_IDLE:
          if (free_blocks < THR && vfound) begin
            vic   <= vsel;
            vkind <= bkind[vsel];
            ptr   <= '0;
            pend  <= 1'b0;
            fin   <= 1'b0;
            st    <= S_SCAN;
          end
        S_SCAN:
          if (mid_flush) st <= S_FLUSH;
          else begin
            if (miss) begin
              pend <= 1'b1;
              ptp  <= s_tp;
            end
            if (ptr == LAST) begin
              fin <= 1'b1;
              st  <= (pend || miss) ? S_FLUSH : S_ERASE;
            end else ptr <= ptr + 1'b1;
          end
        S_FLUSH: begin
          pend <= 1'b0;
          st   <= fin ? S_ERASE : S_SCAN;
        end
        default: begin
          for (int p = 0; p < PPB; p++) pst[{vic, OW'(p)}] <= PG_ERASED;
          bst[vic] <= BK_FREE;
          st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/fgc_reloc_chk.sv
module fgc_reloc_chk #(
  parameter int PW = 5,
  parameter int FW = 4,
  parameter int LW = 8,
  parameter int THRESH = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_ready,
  input logic          gc_busy,
  input logic [FW-1:0] free_blocks,
  input logic          cmd_vld,
  input logic [1:0]    cmd_op,
  input logic          cache_hit,
  input logic          cache_wr,
  input logic          stage_wr,
  input logic          gtd_wr,
  input logic [LW-1:0] gtd_idx,
  input logic [LW-1:0] gtd_rd_idx
);
  a_r3_hold_writes: assert property (@(posedge clk) disable iff (!rst_n)
    gc_busy |-> !wr_ready);

  a_r3_start_below_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gc_busy) |-> $past(free_blocks) < FW'(THRESH));

  a_r5_trans_copy_patches_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 2'd1 && !cache_wr && !stage_wr) |-> gtd_wr);

  a_r6_cache_update_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    cache_wr |-> (cache_hit && !stage_wr));

  a_r7_stage_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    stage_wr |-> !cache_hit);

  a_r8_rewrite_updates_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 2'd2) |-> (gtd_wr && gtd_idx == gtd_rd_idx));

  a_r9_erase_frees_block: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 2'd3) |=> free_blocks == $past(free_blocks) + 1'b1);
endmodule

bind fgc_reloc fgc_reloc_chk #(.PW(PW), .FW(BW+1), .LW(LW), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .gc_busy(gc_busy),
  .free_blocks(free_blocks), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
  .cache_hit(cache_hit), .cache_wr(cache_wr), .stage_wr(stage_wr),
  .gtd_wr(gtd_wr), .gtd_idx(gtd_idx), .gtd_rd_idx(gtd_rd_idx)
);

// File: tb/fgc_reloc_test.sv
module fgc_reloc_test;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic       wr_en = 0, wr_kind = 0, wr_old_vld = 0;
  logic [7:0] wr_lpn = 0;
  logic [4:0] wr_old_ppn = 0, wr_ppn, cmd_src, cmd_dst, map_ppn, gtd_ppn, gtd_rd_ppn;
  logic       wr_ready, gc_busy, cmd_vld, cache_hit, cache_wr, stage_wr, gtd_wr, gtd_rd_vld;
  logic [3:0] free_blocks;
  logic [1:0] cmd_op;
  logic [7:0] map_lpn, gtd_idx, gtd_rd_idx;

  logic       hitmap [256];
  logic [4:0] gtd_m  [256];
  logic       gtd_v  [256];
  initial for (int i = 0; i < 256; i++) begin hitmap[i] = 0; gtd_m[i] = 0; gtd_v[i] = 0; end
  assign cache_hit  = hitmap[map_lpn];
  assign gtd_rd_vld = gtd_v[gtd_rd_idx];
  assign gtd_rd_ppn = gtd_m[gtd_rd_idx];
  always @(posedge clk) if (gtd_wr) begin gtd_m[gtd_idx] <= gtd_ppn; gtd_v[gtd_idx] <= 1; end

  fgc_reloc uut (.*);

  logic [23:0] ev [64];
  int nev = 0;
  always @(negedge clk) if (rst_n) begin
    if (cmd_vld && nev < 64) begin ev[nev] = {6'd0, cmd_op, 3'd0, (cmd_op == 2'd3) ? 5'd0 : cmd_src, 3'd0, cmd_dst}; nev++; end
    if (gtd_wr && nev < 64)   begin ev[nev] = {8'd4, gtd_idx, 3'd0, gtd_ppn}; nev++; end
    if (cache_wr && nev < 64) begin ev[nev] = {8'd5, map_lpn, 3'd0, map_ppn}; nev++; end
    if (stage_wr && nev < 64) begin ev[nev] = {8'd6, map_lpn, 3'd0, map_ppn}; nev++; end
  end

  int ntot = 0, npass = 0;
  task automatic chk(input string tag, input int act, input int exp);
    ntot++;
    if (act == exp) npass++;
    else $display("FAIL %s actual %0d expected %0d", tag, act, exp);
  endtask

  task automatic wr(input logic k, input int lpn, input logic ov, input int oppn, input int exp, input string tag);
    @(posedge clk); #1;
    chk({tag, " ready"}, int'(wr_ready), 1);
    wr_en = 1; wr_kind = k; wr_lpn = 8'(lpn); wr_old_vld = ov; wr_old_ppn = 5'(oppn);
    #2 chk({tag, " ppn"}, int'(wr_ppn), exp);
    @(posedge clk); #1 wr_en = 0; wr_old_vld = 0;
  endtask

  task automatic exp_ev(input int base, input int i, input int t, input int a, input int b, input string tag);
    chk(tag, int'(ev[base + i]), (t << 16) | (a << 8) | b);
  endtask

  task automatic settle();
    repeat (40) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R10 free after reset", int'(free_blocks), 6);
    chk("R10 ready after reset", int'(wr_ready), 1);
    chk("R10 busy after reset", int'(gc_busy), 0);
  endtask

  task automatic t_first_gc();
    int base;
    for (int i = 0; i < 4; i++) wr(0, i, 0, 0, i, "R1 data fill block0");
    wr(1, 0, 0, 0, 4, "R1 translation pool own block");
    for (int i = 4; i < 8; i++) wr(0, i, 0, 0, i + 4, "R1 next lowest free block");
    wr(0, 0, 1, 0, 12, "R2 overwrite lpn0");
    wr(0, 1, 1, 1, 13, "R2 overwrite lpn1");
    wr(0, 2, 1, 2, 14, "R2 overwrite lpn2");
    wr(0, 4, 1, 8, 15, "R2 overwrite lpn4");
    for (int i = 8; i < 13; i++) wr(0, i, 0, 0, i + 8, "R1 data fill");
    chk("R3 at threshold free", int'(free_blocks), 2);
    chk("R3 at threshold no gc", int'(gc_busy), 0);
    wr(0, 13, 0, 0, 21, "R1 data fill");
    wr(0, 14, 0, 0, 22, "R1 data fill");
    hitmap[3] = 1;
    base = nev;
    wr(0, 15, 0, 0, 23, "R1 data fill");
    chk("R3 ready low below threshold", int'(wr_ready), 0);
    settle();
    chk("R4 unique minimum event count", nev - base, 3);
    exp_ev(base, 0, 1, 3, 24, "R4 victim block0 copy");
    exp_ev(base, 1, 5, 3, 24, "R6 cache update on hit");
    exp_ev(base, 2, 3, 0, 0, "R9 erase block0");
    chk("R9 free after erase", int'(free_blocks), 2);
  endtask

  task automatic t_batch();
    int base;
    wr(0, 16, 0, 0, 25, "R1 data fill");
    wr(0, 0, 1, 12, 26, "R2 overwrite to tie");
    base = nev;
    wr(0, 18, 0, 0, 27, "R1 reuse erased block0 next");
    settle();
    chk("R7 batch event count", nev - base, 9);
    exp_ev(base, 0, 1, 9, 0, "R4 tie lowest block2, R9 reuse block0");
    exp_ev(base, 1, 6, 5, 0, "R7 stage lpn5");
    exp_ev(base, 2, 1, 10, 1, "R7 copy");
    exp_ev(base, 3, 6, 6, 1, "R7 stage lpn6");
    exp_ev(base, 4, 1, 11, 2, "R7 copy");
    exp_ev(base, 5, 6, 7, 2, "R7 stage lpn7");
    exp_ev(base, 6, 2, 0, 5, "R8 single rewrite no old page");
    exp_ev(base, 7, 4, 1, 5, "R8 directory write");
    exp_ev(base, 8, 3, 0, 8, "R9 erase block2");
  endtask

  task automatic t_trans();
    int base;
    wr(1, 0, 1, 4, 6, "R1 translation append");
    base = nev;
    wr(1, 1, 1, 5, 7, "R1 translation append");
    settle();
    chk("R5 event count", nev - base, 5);
    exp_ev(base, 0, 1, 6, 8, "R5 copy tpage0");
    exp_ev(base, 1, 4, 0, 8, "R5 dir patch tpage0");
    exp_ev(base, 2, 1, 7, 9, "R5 copy tpage1");
    exp_ev(base, 3, 4, 1, 9, "R5 dir patch tpage1");
    exp_ev(base, 4, 3, 0, 4, "R9 erase block1");
  endtask

  task automatic t_mixed();
    int base;
    hitmap[2] = 1;
    base = nev;
    wr(0, 20, 0, 0, 3, "R1 last page of block0");
    settle();
    chk("R7 mixed event count", nev - base, 16);
    exp_ev(base, 0, 1, 13, 4, "R7 copy lpn1");
    exp_ev(base, 1, 6, 1, 4, "R7 stage lpn1");
    exp_ev(base, 2, 1, 14, 5, "R6 copy lpn2");
    exp_ev(base, 3, 5, 2, 5, "R6 cache lpn2");
    exp_ev(base, 4, 2, 8, 10, "R7 flush before new tpage, R8 src old");
    exp_ev(base, 5, 4, 0, 10, "R8 dir tpage0");
    exp_ev(base, 6, 1, 15, 6, "R7 copy lpn4 after flush");
    exp_ev(base, 7, 6, 4, 6, "R7 stage lpn4");
    exp_ev(base, 8, 2, 9, 11, "R8 final flush");
    exp_ev(base, 9, 4, 1, 11, "R8 dir tpage1");
    exp_ev(base, 10, 3, 0, 12, "R9 erase block3");
    exp_ev(base, 11, 1, 10, 28, "R2 R5 follow-on victim block2");
    exp_ev(base, 12, 4, 0, 28, "R5 dir");
    exp_ev(base, 13, 1, 11, 29, "R5 copy");
    exp_ev(base, 14, 4, 1, 29, "R5 dir");
    exp_ev(base, 15, 3, 0, 8, "R9 erase block2");
    chk("R9 free after both", int'(free_blocks), 2);
    wr(0, 21, 0, 0, 7, "R1 data continues in block1");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_first_gc();
    t_batch();
    t_trans();
    t_mixed();
    $display("%0d/%0d checks passed", npass, ntot);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog actual hung expected finish");
    $display("%0d/%0d checks passed", npass, ntot + 1);
    $finish;
  end
endmodule